// File: doc/BRIEF.md
# Guarded clock-divide select register

This block is an 8-bit control register, mapped onto a simple bus, that holds the 4-bit select code for a system clock divider. The select code can only be changed through a two-step sequence. First, software writes a key value that sets a change-enable flag. Then, within a four-cycle window, it writes the new select value. Without this sequence, a stray bus write cannot change the clock rate.

The select value that reset loads depends on a boot-time option input. While that option is active, the part starts at a slower rate. An accepted select write produces a one-cycle update strobe, together with the new code, for the divider that sits downstream. The divider itself and interrupt masking are outside this block.

Top module: `prescale_ctl`

## Requirements
- R1: After reset the change-enable flag is zero, the update strobe is low, and a read returns change-enable in bit 7 and the select code in bits 3 to 0.
- R2: Bits 6 to 4 of the register always read as zero, whatever value is written to them.
- R3: Change-enable is set only by a write of exactly 8'h80 (bit 7 one, all other bits zero). Any other write pattern leaves it unchanged.
- R4: A write with bit 7 equal to zero, made while change-enable is set, loads wdata bits 3 to 0 into the select code.
- R5: Change-enable stays set for four clock cycles after the cycle in which the key write is captured, and then clears. An accepted select write clears it in the same cycle.
- R6: A repeated key write while change-enable is set neither restarts the four-cycle window nor clears the flag.
- R7: On reset the select code becomes 4'b0000 when boot_div8_i is low and 4'b0011 when boot_div8_i is high.
- R8: After unlocking, any select value can be written, whatever the level of boot_div8_i.
- R9: A select write made while change-enable is clear is ignored. The select code keeps its value and no strobe is produced.
- R10: Each accepted select write raises div_upd_o for exactly one cycle, and div_sel_o shows the new code in that same cycle.
- R11: Reads have no side effect on change-enable, on the window, or on the select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_div8_i | input | 1 | Boot option that selects the reset value of the select code |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when rd_i is low |
| div_sel_o | output | 4 | Current divide select code |
| div_upd_o | output | 1 | One-cycle strobe marking an accepted select write |

## Verification
The bench writes several kinds of data patterns:
- The exact key and keys with one stray bit, which separate a strict pattern match from a test of bit 7 alone.
- Select writes with no prior unlock, in the last slot of the window and one cycle past it, which pin down the window length at both edges.
- A repeated key in mid-window, which shows whether the timer restarts.
- Select data with the reserved bits set, together with reads during an open window, which show that reserved bits and reads leave the state alone.

Both levels of the boot option are exercised across separate resets.

// File: rtl/prescale_ctl_pkg.sv
package prescale_ctl_pkg;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned SEL_W  = 4;
  parameter int unsigned WIN    = 4;
  localparam int unsigned CE_BIT = DATA_W - 1;
  localparam int unsigned CNT_W  = $clog2(WIN + 1);
  localparam logic [DATA_W-1:0] KEY = DATA_W'(1) << CE_BIT;
  localparam logic [SEL_W-1:0] BOOT_SEL = SEL_W'(3);
endpackage

// File: rtl/prescale_ctl_decode.sv
module prescale_ctl_decode
  import prescale_ctl_pkg::*;
(
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              key_hit_o,
  output logic              sel_hit_o
);
  // key must match exactly; select writes need bit 7 low
  assign key_hit_o = wr_i && (wdata_i == KEY);
  assign sel_hit_o = wr_i && !wdata_i[CE_BIT];
endmodule

// File: rtl/prescale_ctl_window.sv
module prescale_ctl_window
  import prescale_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_hit_i,
  input  logic sel_take_i,
  output logic ce_o
);
  logic             ce_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q  <= 1'b0;
      cnt_q <= '0;
    end else if (sel_take_i) begin
      ce_q  <= 1'b0;
      cnt_q <= '0;
    end else if (ce_q) begin
      // key rewrite ignored while open
      if (cnt_q == '0) ce_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (key_hit_i) begin
      ce_q  <= 1'b1;
      cnt_q <= CNT_W'(WIN - 1);
    end
  end

  assign ce_o = ce_q;
endmodule

// File: rtl/prescale_ctl_select.sv
module prescale_ctl_select
  import prescale_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_div8_i,
  input  logic             take_i,
  input  logic [SEL_W-1:0] sel_d_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             upd_o
);
  logic [SEL_W-1:0] sel_q;
  logic             upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= boot_div8_i ? BOOT_SEL : '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= take_i;
      if (take_i) sel_q <= sel_d_i;
    end
  end

  assign sel_o = sel_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/prescale_ctl.sv
module prescale_ctl
  import prescale_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_div8_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  div_sel_o,
  output logic              div_upd_o
);
  localparam int unsigned RSV_W = DATA_W - SEL_W - 1;

  logic key_hit, sel_hit, sel_take, ce;

  prescale_ctl_decode u_dec (
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .key_hit_o(key_hit),
    .sel_hit_o(sel_hit)
  );

  assign sel_take = sel_hit && ce;

  prescale_ctl_window u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_hit_i (key_hit),
    .sel_take_i(sel_take),
    .ce_o      (ce)
  );

  prescale_ctl_select u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_div8_i(boot_div8_i),
    .take_i     (sel_take),
    .sel_d_i    (wdata_i[SEL_W-1:0]),
    .sel_o      (div_sel_o),
    .upd_o      (div_upd_o)
  );

  assign rdata_o = rd_i ? {ce, {RSV_W{1'b0}}, div_sel_o} : '0;
endmodule

// File: rtl/prescale_ctl_chk.sv
module prescale_ctl_chk
  import prescale_ctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [SEL_W-1:0]  div_sel_o,
  input logic              div_upd_o,
  input logic              ce
);
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  run_q <= '0;
    else if (!ce) run_q <= '0;
    else          run_q <= run_q + 1'b1;
  end

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-2:SEL_W] == '0);  // R2
  AST_CE_BY_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce) |-> $past(wr_i && wdata_i == KEY));  // R3
  AST_CE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= (CNT_W+1)'(WIN));  // R5
  AST_UPD_CLEARS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_upd_o |-> !ce);  // R5
  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce |=> $stable(div_sel_o));  // R9
  AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_upd_o |=> !div_upd_o);  // R10
  AST_UPD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_upd_o |-> div_sel_o == $past(wdata_i[SEL_W-1:0]));  // R4
  AST_READ_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && !ce) |=> !ce);  // R11
endmodule

bind prescale_ctl prescale_ctl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .div_sel_o(div_sel_o),
  .div_upd_o(div_upd_o),
  .ce       (ce)
);

// File: tb/prescale_ctl_test.sv
`timescale 1ns/1ps
module prescale_ctl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       boot_div8_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] div_sel_o;
  logic       div_upd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  prescale_ctl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .boot_div8_i(boot_div8_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .div_sel_o(div_sel_o), .div_upd_o(div_upd_o)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit boot);
    @(negedge clk_i);
    boot_div8_i = boot;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // write captured at next posedge; returns at following negedge
  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(output logic [7:0] d);
    rd_i = 1'b1;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    do_reset(1'b0);
    rd(r);
    check(r == 8'h00, "R1 reset read", r, 8'h00);
    check(div_upd_o == 1'b0, "R1 strobe low", {7'b0, div_upd_o}, 8'h00);
    do_reset(1'b1);
    rd(r);
    check(r == 8'h03, "R7 boot reset value", r, 8'h03);
    do_reset(1'b0);
    check(div_sel_o == 4'h0, "R7 plain reset value", {4'b0, div_sel_o}, 8'h00);
  endtask

  task automatic t_locked;
    logic [7:0] r;
    wr(8'h05);
    check(div_upd_o == 1'b0, "R9 no strobe when locked", {7'b0, div_upd_o}, 8'h00);
    rd(r);
    check(r == 8'h00, "R9 locked write ignored", r, 8'h00);
  endtask

  task automatic t_bad_keys;
    logic [7:0] r;
    wr(8'h81);
    rd(r);
    check(r == 8'h00, "R3 key with bit0 rejected", r, 8'h00);
    wr(8'hC0);
    rd(r);
    check(r == 8'h00, "R3 key with bit6 rejected", r, 8'h00);
  endtask

  task automatic t_unlock_write;
    logic [7:0] r;
    wr(8'h80);
    rd(r);
    check(r == 8'h80, "R3 key sets enable", r, 8'h80);
    wr(8'h0A);
    check(div_upd_o == 1'b1, "R10 strobe on accept", {7'b0, div_upd_o}, 8'h01);
    check(div_sel_o == 4'hA, "R4 select loaded", {4'b0, div_sel_o}, 8'h0A);
    rd(r);
    check(r == 8'h0A, "R5 enable cleared by write", r, 8'h0A);
    @(negedge clk_i);
    check(div_upd_o == 1'b0, "R10 strobe one cycle", {7'b0, div_upd_o}, 8'h00);
  endtask

  task automatic t_last_slot;
    logic [7:0] r;
    wr(8'h80);
    idle(2);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = 8'h06;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
    check(div_sel_o == 4'h6, "R5 fourth slot accepted", {4'b0, div_sel_o}, 8'h06);
    wr(8'h80);
    idle(3);
    rd(r);
    check(r == 8'h86, "R5 enable held four cycles", r, 8'h86);
    wr(8'h02);
    check(div_sel_o == 4'h6, "R5 write after window ignored", {4'b0, div_sel_o}, 8'h06);
    check(div_upd_o == 1'b0, "R9 no strobe after window", {7'b0, div_upd_o}, 8'h00);
  endtask

  task automatic t_rekey;
    logic [7:0] r;
    wr(8'h80);
    wr(8'h80);
    rd(r);
    check(r == 8'h86, "R6 rekey keeps enable", r, 8'h86);
    idle(1);
    rd(r);
    check(r == 8'h86, "R6 enable still set", r, 8'h86);
    idle(1);
    rd(r);
    check(r == 8'h06, "R6 window not extended", r, 8'h06);
  endtask

  task automatic t_reads_rsv;
    logic [7:0] r;
    wr(8'h80);
    for (int i = 0; i < 2; i++) begin
      rd_i = 1'b1;
      @(negedge clk_i);
    end
    rd_i = 1'b0;
    rd(r);
    check(r == 8'h86, "R11 reads leave window", r, 8'h86);
    wr(8'h7C);
    rd(r);
    check(r == 8'h0C, "R2 reserved bits read zero", r, 8'h0C);
  endtask

  task automatic t_boot_any;
    logic [7:0] r;
    do_reset(1'b1);
    wr(8'h80);
    wr(8'h00);
    rd(r);
    check(r == 8'h00, "R8 zero written under boot option", r, 8'h00);
    wr(8'h80);
    wr(8'h0F);
    check(div_sel_o == 4'hF, "R8 max code written", {4'b0, div_sel_o}, 8'h0F);
  endtask

  initial begin
    t_reset();
    t_locked();
    t_bad_keys();
    t_unlock_write();
    t_last_slot();
    t_rekey();
    t_reads_rsv();
    t_boot_any();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule